// File: doc/BRIEF.md
# Debug Sequential Breakpoint Status Controller

This block is the status unit of an on-chip debug controller. It records the reasons the processor stopped for debug and runs a three-stage breakpoint chain. The first memory breakpoint match arms the second. The second match starts a trace down-counter, which steps once for each retired instruction. When that counter expires with trace enabled, the block raises a one-cycle request for debug entry.

Each cause flag stays set until one of two things happens: a test-logic reset, or a debug-exit command that carries both its go and execute bits. Any other exit command changes nothing. When sequential operation is off, each breakpoint match requests debug entry directly and the chain is bypassed. A debugger reads one seven-bit status word. It holds the processor mode and the five flags.

Top module: `dbg_seq_status`

## Requirements
- R1: While the active-low test-logic reset is asserted, and in the cycle after it is released, `status` is all zeros and `dbgReq` is 0.
- R2: `status[1:0]` shows the `procMode` value sampled on the previous clock edge. The encodings are 00 normal run, 01 stop/doze/wait, 10 debug and 11 reserved.
- R3: With `seqEn` high, a `bkptA` pulse sets the A-arm flag `status[2]` on the next edge.
- R4: With `seqEn` high, a `bkptB` pulse sets the B-arm flag `status[3]` only if the A-arm flag was already set before that edge. Otherwise the pulse is ignored.
- R5: The trace counter holds `traceLoad` until the B-arm flag is set.
  - After that, each `instRetire` cycle with `traceEn` high decrements the counter by one.
  - The step from 1 to 0 sets the trace flag `status[5]` and drives `dbgReq` high for exactly one cycle.
  - A count of 0 never expires.
- R6: A `swBkpt` strobe sets `status[6]`. A `fifoFreeze` strobe sets `status[4]`.
- R7: Flags in `status[6:2]` are sticky.
  - An `exitCmd` with both `exitGo` and `exitEx` high clears them on the next edge and reloads the counter.
  - The clear wins over any set in the same cycle.
- R8: An `exitCmd` without both `exitGo` and `exitEx` high leaves `status[6:2]` unchanged.
- R9: With `seqEn` low, a `bkptA` or `bkptB` pulse drives `dbgReq` high on the next edge. It leaves `status[3:2]` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| tlRstN | input | 1 | Test-logic reset, asynchronous, active low |
| seqEn | input | 1 | Sequential breakpoint chain enable |
| traceEn | input | 1 | Trace counting enable |
| traceLoad | input | TRACE_W | Trace counter reload value |
| bkptA | input | 1 | Breakpoint A match pulse |
| bkptB | input | 1 | Breakpoint B match pulse |
| swBkpt | input | 1 | Software breakpoint executed strobe |
| fifoFreeze | input | 1 | FIFO freeze event strobe |
| instRetire | input | 1 | Retired instruction strobe |
| procMode | input | 2 | Processor mode from the CPU |
| exitCmd | input | 1 | Debug exit command strobe |
| exitGo | input | 1 | Go bit of the exit command |
| exitEx | input | 1 | Execute bit of the exit command |
| status | output | 7 | Read-only status word |
| dbgReq | output | 1 | Debug entry request pulse |

## Verification
Every result of this block comes from a register, so each one is due exactly one edge after the input cycle that causes it. This holds for the mode field, every flag set, a clear, the direct request, and an expiry request. An expiry is due one edge after the retire strobe that takes the count from 1 to 0. The bench drives inputs on falling edges and updates its reference model on the rising edge that captures them. It compares the design with the model on the next falling edge. Directed checks read the output after exactly one such step, and the one-cycle request width is confirmed one step later.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;

  localparam int STAT_W   = 7;
  localparam int FLAG_N   = 5;
  localparam int BIT_ARMA = 2;
  localparam int BIT_ARMB = 3;
  localparam int BIT_FRZ  = 4;
  localparam int BIT_TRC  = 5;
  localparam int BIT_SW   = 6;

  typedef enum logic [1:0] {
    MODE_RUN    = 2'b00,
    MODE_LOWPWR = 2'b01,
    MODE_DEBUG  = 2'b10,
    MODE_RSVD   = 2'b11
  } procMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic setArmA;
    logic setArmB;
    logic setFreeze;
    logic setTrace;
    logic setSw;
    logic clearAll;
    logic cntDec;
    logic reqNow;
  } seqStrobes_t;

endpackage

// File: rtl/dbg_seq_ctrl.sv
module dbg_seq_ctrl
  import dbg_seq_pkg::*;
(
  input  logic        seqEn,
  input  logic        traceEn,
  input  logic        bkptA,
  input  logic        bkptB,
  input  logic        swBkpt,
  input  logic        fifoFreeze,
  input  logic        instRetire,
  input  logic        exitCmd,
  input  logic        exitGo,
  input  logic        exitEx,
  input  logic        armA,
  input  logic        armB,
  input  logic        cntIsOne,
  output seqStrobes_t strb
);

  logic directReq;
  logic expire;

  always_comb begin
    directReq = !seqEn && (bkptA || bkptB);
    strb.cntDec = armB && traceEn && instRetire;
    expire = strb.cntDec && cntIsOne;

    strb.clearAll  = exitCmd && exitGo && exitEx;
    strb.setArmA   = seqEn && bkptA;
    // B only counts once A has been seen
    strb.setArmB   = seqEn && bkptB && armA;
    strb.setFreeze = fifoFreeze;
    strb.setSw     = swBkpt;
    strb.setTrace  = expire;
    strb.reqNow    = directReq || expire;
  end

endmodule

// File: rtl/dbg_seq_dp.sv
module dbg_seq_dp
  import dbg_seq_pkg::*;
#(
  parameter int TRACE_W = 8
) (
  input  logic               clk,
  input  logic               tlRstN,
  input  seqStrobes_t        strb,
  input  logic [TRACE_W-1:0] traceLoad,
  input  logic [1:0]         procMode,
  output logic               armA,
  output logic               armB,
  output logic               cntIsOne,
  output logic [STAT_W-1:0]  status,
  output logic               dbgReq
);

  localparam logic [TRACE_W-1:0] CNT_ONE = TRACE_W'(1);

  logic [FLAG_N-1:0]  setVec;
  logic [FLAG_N-1:0]  flagQ;
  logic [TRACE_W-1:0] cntQ;
  logic [1:0]         modeQ;

  assign setVec = {strb.setSw, strb.setTrace, strb.setFreeze,
                   strb.setArmB, strb.setArmA};

  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    always_ff @(posedge clk or negedge tlRstN) begin
      if (!tlRstN)            flagQ[i] <= 1'b0;
      else if (strb.clearAll) flagQ[i] <= 1'b0;
      else if (setVec[i])     flagQ[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge tlRstN) begin
    if (!tlRstN)
      cntQ <= '0;
    else if (strb.clearAll || !armB)
      cntQ <= traceLoad;
    else if (strb.cntDec && (cntQ != '0))
      cntQ <= cntQ - CNT_ONE;
  end

  always_ff @(posedge clk or negedge tlRstN) begin
    if (!tlRstN) begin
      modeQ  <= MODE_RUN;
      dbgReq <= 1'b0;
    end else begin
      modeQ  <= procMode;
      dbgReq <= strb.reqNow;
    end
  end

  assign armA     = flagQ[BIT_ARMA-2];
  assign armB     = flagQ[BIT_ARMB-2];
  assign cntIsOne = (cntQ == CNT_ONE);
  assign status   = {flagQ, modeQ};

endmodule

// File: rtl/dbg_seq_status.sv
module dbg_seq_status
  import dbg_seq_pkg::*;
#(
  parameter int TRACE_W = 8
) (
  input  logic               clk,
  input  logic               tlRstN,
  input  logic               seqEn,
  input  logic               traceEn,
  input  logic [TRACE_W-1:0] traceLoad,
  input  logic               bkptA,
  input  logic               bkptB,
  input  logic               swBkpt,
  input  logic               fifoFreeze,
  input  logic               instRetire,
  input  logic [1:0]         procMode,
  input  logic               exitCmd,
  input  logic               exitGo,
  input  logic               exitEx,
  output logic [6:0]         status,
  output logic               dbgReq
);

  seqStrobes_t strb;
  logic armA, armB, cntIsOne;

  dbg_seq_ctrl u_ctrl (
    .seqEn(seqEn), .traceEn(traceEn), .bkptA(bkptA), .bkptB(bkptB),
    .swBkpt(swBkpt), .fifoFreeze(fifoFreeze), .instRetire(instRetire),
    .exitCmd(exitCmd), .exitGo(exitGo), .exitEx(exitEx),
    .armA(armA), .armB(armB), .cntIsOne(cntIsOne), .strb(strb)
  );

  dbg_seq_dp #(.TRACE_W(TRACE_W)) u_dp (
    .clk(clk), .tlRstN(tlRstN), .strb(strb), .traceLoad(traceLoad),
    .procMode(procMode), .armA(armA), .armB(armB), .cntIsOne(cntIsOne),
    .status(status), .dbgReq(dbgReq)
  );

endmodule

// File: rtl/dbg_seq_chk.sv
module dbg_seq_chk (
  input logic       clk,
  input logic       tlRstN,
  input logic       seqEn,
  input logic       bkptA,
  input logic       bkptB,
  input logic [1:0] procMode,
  input logic       exitCmd,
  input logic       exitGo,
  input logic       exitEx,
  input logic [6:0] status,
  input logic       dbgReq
);

  logic warm;
  logic clr;

  always_ff @(posedge clk or negedge tlRstN) begin
    if (!tlRstN) warm <= 1'b0;
    else         warm <= 1'b1;
  end

  assign clr = exitCmd && exitGo && exitEx;

  a_r2_mode_follows: assert property (@(posedge clk) disable iff (!tlRstN)
    warm |-> status[1:0] == $past(procMode));

  a_r4_b_after_a: assert property (@(posedge clk) disable iff (!tlRstN)
    $rose(status[3]) |-> $past(status[2]));

  a_r5_trace_with_req: assert property (@(posedge clk) disable iff (!tlRstN)
    $rose(status[5]) |-> dbgReq);

  a_r7_full_exit_clears: assert property (@(posedge clk) disable iff (!tlRstN)
    clr |=> status[6:2] == 5'b0);

  for (genvar i = 2; i < 7; i++) begin : g_sticky
    a_r7_sticky: assert property (@(posedge clk) disable iff (!tlRstN)
      status[i] && !clr |=> status[i]);
  end

  a_r9_direct_req: assert property (@(posedge clk) disable iff (!tlRstN)
    !seqEn && (bkptA || bkptB) && !clr |=> dbgReq && $stable(status[3:2]));

endmodule

bind dbg_seq_status dbg_seq_chk u_chk (
  .clk(clk), .tlRstN(tlRstN), .seqEn(seqEn), .bkptA(bkptA), .bkptB(bkptB),
  .procMode(procMode), .exitCmd(exitCmd), .exitGo(exitGo), .exitEx(exitEx),
  .status(status), .dbgReq(dbgReq)
);

// File: tb/tb_dbg_seq_status.sv
`timescale 1ns/1ps
module tb_dbg_seq_status;
  import dbg_seq_pkg::*;

  localparam int TW = 8;

  logic clk = 1'b0;
  logic tlRstN = 1'b0;
  logic seqEn = 1'b1, traceEn = 1'b1;
  logic [TW-1:0] traceLoad = 8'd3;
  logic bkptA = 0, bkptB = 0, swBkpt = 0, fifoFreeze = 0, instRetire = 0;
  logic [1:0] procMode = 2'b00;
  logic exitCmd = 0, exitGo = 0, exitEx = 0;
  logic [6:0] status;
  logic dbgReq;

  int checks = 0;
  int failures = 0;
  bit cmpOn = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dbg_seq_status #(.TRACE_W(TW)) dut (.*);

  // behavioural reference model
  bit mA, mB, mF, mT, mS, mReq;
  int mCnt;
  int mMode;

  always @(posedge clk) begin
    if (!tlRstN) begin
      {mA, mB, mF, mT, mS, mReq} = '0;
      mCnt = 0; mMode = 0;
    end else begin
      bit clrNow, dec, exp;
      clrNow = exitCmd && exitGo && exitEx;
      dec = mB && traceEn && instRetire;
      exp = dec && (mCnt == 1);
      mReq = (!seqEn && (bkptA || bkptB)) || exp;
      mMode = procMode;
      if (clrNow) begin
        {mA, mB, mF, mT, mS} = '0;
        mCnt = traceLoad;
      end else begin
        if (!mB) mCnt = traceLoad;
        else if (dec && mCnt != 0) mCnt = mCnt - 1;
        if (seqEn && bkptB && mA) mB = 1;
        if (seqEn && bkptA) mA = 1;
        if (fifoFreeze) mF = 1;
        if (swBkpt) mS = 1;
        if (exp) mT = 1;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmpOn) begin
      chk("R2 mode", status[1:0], mMode);
      chk("R3 armA", status[2], mA);
      chk("R4 armB", status[3], mB);
      chk("R6 freeze", status[4], mF);
      chk("R5 trace", status[5], mT);
      chk("R6 sw", status[6], mS);
      chk("R5 dbgReq", dbgReq, mReq);
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic idle();
    {bkptA, bkptB, swBkpt, fifoFreeze, instRetire, exitCmd, exitGo, exitEx} = '0;
  endtask

  task automatic fullExit();
    exitCmd = 1; exitGo = 1; exitEx = 1; tick(); idle();
  endtask

  initial begin
    #100000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    chk("R1 reset status", status, 0);
    chk("R1 reset req", dbgReq, 0);
    tlRstN = 1'b1;
    tick();
    chk("R1 after release", status, 0);
    cmpOn = 1;

    // R2 mode sweep
    for (int m = 0; m < 4; m++) begin
      procMode = 2'(m); tick();
      chk("R2 mode field", status[1:0], m);
    end
    procMode = MODE_RUN;

    // R4: B before A is ignored
    bkptB = 1; tick(); idle();
    chk("R4 B ignored without A", status[3], 0);

    // R3
    bkptA = 1; tick(); idle();
    chk("R3 A arms", status[2], 1);

    // R4
    bkptB = 1; tick(); idle();
    chk("R4 B arms", status[3], 1);

    // R5 three retires with load 3
    instRetire = 1; tick(); chk("R5 no early req", dbgReq, 0);
    tick(); chk("R5 no early req", dbgReq, 0);
    tick(); idle();
    chk("R5 expiry req", dbgReq, 1);
    chk("R5 trace flag", status[5], 1);
    tick();
    chk("R5 req one cycle", dbgReq, 0);

    // R6
    swBkpt = 1; fifoFreeze = 1; tick(); idle();
    chk("R6 sw flag", status[6], 1);
    chk("R6 freeze flag", status[4], 1);

    // R8 partial exits
    exitCmd = 1; exitGo = 1; tick(); idle();
    chk("R8 go only keeps flags", status[6:2], 5'h1f);
    exitCmd = 1; exitEx = 1; tick(); idle();
    chk("R8 ex only keeps flags", status[6:2], 5'h1f);

    // R7 full exit
    fullExit();
    chk("R7 clear", status[6:2], 0);

    // R7 clear beats set
    exitCmd = 1; exitGo = 1; exitEx = 1; bkptA = 1; swBkpt = 1; tick(); idle();
    chk("R7 clear wins", status[6:2], 0);

    // R9 direct mode
    seqEn = 0; bkptA = 1; tick(); idle();
    chk("R9 direct req A", dbgReq, 1);
    chk("R9 no arm A", status[2], 0);
    bkptB = 1; tick(); idle();
    chk("R9 direct req B", dbgReq, 1);
    chk("R9 no arm B", status[3], 0);
    tick();
    seqEn = 1;

    // R5 load 0 never expires
    traceLoad = 0;
    bkptA = 1; tick(); idle();
    bkptB = 1; tick(); idle();
    instRetire = 1; repeat (6) tick(); idle(); tick();
    chk("R5 zero load no expiry", status[5], 0);

    // R5 traceEn pause
    fullExit();
    traceLoad = 2;
    bkptA = 1; tick(); idle();
    bkptB = 1; tick(); idle();
    traceEn = 0; instRetire = 1; repeat (3) tick();
    chk("R5 paused no trace", status[5], 0);
    traceEn = 1; tick(); tick(); idle();
    chk("R5 resumed expiry", dbgReq, 1);
    tick();

    // R7 chain rearms after exit
    fullExit();
    chk("R7 arms cleared", status[3:2], 0);
    bkptB = 1; tick(); idle();
    chk("R4 B ignored after exit", status[3], 0);

    repeat (4) tick();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule